// File: doc/BRIEF.md
# Indexed Real-Time Clock

This block keeps calendar time (seconds, minutes, hours, day of month, month and a two-digit year) and exposes it, together with two status bytes and a small array of general-purpose bytes, through a pair of byte-wide I/O ports. Software first writes a register number to the index port. It then reads or writes that register through the data port. Reads are combinational, so the byte reflects the selected register in the same cycle.

A cycle counter in the sequencer state machine divides the core clock down to one update per second. For a fixed number of clocks before each update, a flag in the first status byte reads 1. Software that sees the flag clear knows that it has at least that many clocks to read all the time fields before they can change. A bit in the second status byte selects how the time fields are presented on the data port: packed decimal (one digit per nibble) or plain binary. Writes to time fields are interpreted in the same way. Hours always count 0 to 23.

The sequencer has three states. `SEQ_COUNT` is the quiet part of the second. It moves to `SEQ_WARN` when the cycle counter reaches `TICKS_PER_SEC-UIP_LEAD-1`. `SEQ_WARN` raises the update flag and moves to `SEQ_COMMIT` when the counter reaches `TICKS_PER_SEC-2`. `SEQ_COMMIT` lasts exactly one cycle: the calendar advances at its closing edge, and the sequencer always returns to `SEQ_COUNT`. The parameters must satisfy `UIP_LEAD >= 2` and `TICKS_PER_SEC > UIP_LEAD + 1`.

Top module: `rtc_indexed`

## Requirements
- R1: A write to the index port (`io_addr == PORT_BASE`) stores the low 6 bits of `io_wdata` as the current register number; bits 7:6 are dropped. Reading the index port returns that number zero-extended to 8 bits.
- R2: Writes to any address other than `PORT_BASE` and `PORT_BASE+1` change no state, and reads there return 0x00.
- R3: Every register number other than 0x00, 0x02, 0x04, 0x07, 0x08, 0x09, 0x0A and 0x0B (including the shutdown byte 0x0F) is a plain storage byte. It reads back the last value written through the data port.
- R4: The seconds register (0x00) advances once every `TICKS_PER_SEC` clocks. The first update becomes visible `TICKS_PER_SEC` clocks after reset is released, and between updates the time fields change only through software writes.
- R5: Bit 7 of status A (0x0A) reads 1 for exactly the last `UIP_LEAD` clocks before each update is visible, and reads 0 in the first clock that shows the updated time.
- R6: Seconds (0x00) and minutes (0x02) wrap from 59 to 0 and carry. Hours (0x04) wrap from 23 to 0 and carry into the day. A field at or above its last value wraps on the next carry into it.
- R7: Day (0x07) wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11; 31 for all others; and 28 for month 2, or 29 when the year is divisible by 4. Month (0x08) wraps from 12 to 1 and carries into the year.
- R8: Year (0x09) wraps from 99 to 0.
- R9: Status B (0x0B) is a fully writable byte. When its bit 2 is 0, time fields are read and written as packed decimal (tens digit in bits 7:4, units digit in bits 3:0). When bit 2 is 1 they are plain binary. The same stored time is shown in either form.
- R10: A data-port write to a time field in the cycle in which the update is applied sets that field to the written value. Every other field still advances, with carries computed from the values held before the update.
- R11: Bits 6:0 of status A are writable storage. Bit 7 ignores writes and always shows the update flag.
- R12: After reset the time is 00:00:00 on day 1 of month 1 of year 0, status B is 0x00 (decimal mode), status A is 0x00, the index is 0 and every storage byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the time base divided by `TICKS_PER_SEC` |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O address; `PORT_BASE` is the index port, `PORT_BASE+1` the data port |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data for the addressed port |

## Verification
The bench drives the clock through complete rollover chains: year end, February of common and leap years, a leap day itself, and a 30-day month. A design with a wrong month table or leap rule would land on the wrong day, and a broken carry chain would leave a higher field unchanged. The update flag is sampled in the cycles on both sides of its rising and falling edges, where an off-by-one sequencer would show the flag one clock late or clear it before the new time is visible. A write is placed exactly in the update cycle, with seconds at 59 and the minute being rewritten, which exposes designs that let the tick overwrite the software value or drop the carry into the untouched field. Format switching checks that a value written in binary reads back as decimal digits, which catches missing or inverted conversion on either path.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [2:0] {
        FLD_SEC,
        FLD_MIN,
        FLD_HOUR,
        FLD_DAY,
        FLD_MON,
        FLD_YEAR,
        FLD_NONE
    } rtc_field_e;

    typedef enum logic [1:0] {
        SEQ_COUNT,
        SEQ_WARN,
        SEQ_COMMIT
    } seq_state_e;

    // Register numbers reached through the index port
    localparam logic [7:0] REG_SEC    = 8'h00;
    localparam logic [7:0] REG_MIN    = 8'h02;
    localparam logic [7:0] REG_HOUR   = 8'h04;
    localparam logic [7:0] REG_DAY    = 8'h07;
    localparam logic [7:0] REG_MON    = 8'h08;
    localparam logic [7:0] REG_YEAR   = 8'h09;
    localparam logic [7:0] REG_STAT_A = 8'h0A;
    localparam logic [7:0] REG_STAT_B = 8'h0B;

    localparam int FMT_BIN_BIT = 2;

    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] year);
        logic [7:0] n;
        case (mon)
            8'd4, 8'd6, 8'd9, 8'd11: n = 8'd30;
            8'd2:                    n = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            default:                 n = 8'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_sequencer.sv
module rtc_sequencer
    import rtc_pkg::*;
#(
    parameter int unsigned TICKS = 32768,
    parameter int unsigned LEAD  = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic uip,
    output logic commit
);

    localparam int unsigned CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_WARN  = CNT_W'(TICKS - LEAD - 1);
    localparam logic [CNT_W-1:0] CNT_ENTER = CNT_W'(TICKS - 2);

    logic [CNT_W-1:0] cnt_q;
    seq_state_e       state_q;
    seq_state_e       state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_COUNT:  if (cnt_q == CNT_WARN)  state_d = SEQ_WARN;
            SEQ_WARN:   if (cnt_q == CNT_ENTER) state_d = SEQ_COMMIT;
            SEQ_COMMIT: state_d = SEQ_COUNT;
            default:    state_d = SEQ_COUNT;
        endcase
    end

    // Outputs
    always_comb begin
        uip    = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            SEQ_COUNT:  ;
            SEQ_WARN:   uip = 1'b1;
            SEQ_COMMIT: begin
                uip    = 1'b1;
                commit = 1'b1;
            end
            default:    ;
        endcase
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic       wr_en,
    input  rtc_field_e wr_field,
    input  logic [7:0] wr_val,
    output rtc_time_t  now
);

    localparam rtc_time_t TIME_RESET = '{year: 8'd0, mon: 8'd1, day: 8'd1,
                                         hour: 8'd0, min: 8'd0, sec: 8'd0};

    rtc_time_t adv;
    rtc_time_t nxt;

    // One-second advance with carries taken from the current values
    always_comb begin
        adv = now;
        if (now.sec >= 8'd59) begin
            adv.sec = 8'd0;
            if (now.min >= 8'd59) begin
                adv.min = 8'd0;
                if (now.hour >= 8'd23) begin
                    adv.hour = 8'd0;
                    if (now.day >= month_days(now.mon, now.year)) begin
                        adv.day = 8'd1;
                        if (now.mon >= 8'd12) begin
                            adv.mon = 8'd1;
                            if (now.year >= 8'd99) begin
                                adv.year = 8'd0;
                            end else begin
                                adv.year = now.year + 8'd1;
                            end
                        end else begin
                            adv.mon = now.mon + 8'd1;
                        end
                    end else begin
                        adv.day = now.day + 8'd1;
                    end
                end else begin
                    adv.hour = now.hour + 8'd1;
                end
            end else begin
                adv.min = now.min + 8'd1;
            end
        end else begin
            adv.sec = now.sec + 8'd1;
        end
    end

    // Software write overrides its own field after the advance
    always_comb begin
        nxt = commit ? adv : now;
        if (wr_en) begin
            case (wr_field)
                FLD_SEC:  nxt.sec  = wr_val;
                FLD_MIN:  nxt.min  = wr_val;
                FLD_HOUR: nxt.hour = wr_val;
                FLD_DAY:  nxt.day  = wr_val;
                FLD_MON:  nxt.mon  = wr_val;
                FLD_YEAR: nxt.year = wr_val;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now <= TIME_RESET;
        end else begin
            now <= nxt;
        end
    end

endmodule

// File: rtl/rtc_scratch.sv
module rtc_scratch #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= 8'h00;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/rtc_indexed.sv
module rtc_indexed
    import rtc_pkg::*;
#(
    parameter logic [7:0]  PORT_BASE     = 8'h70,
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned UIP_LEAD      = 8,
    parameter int unsigned NV_BYTES      = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] io_addr,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata
);

    localparam int unsigned IDX_W     = $clog2(NV_BYTES);
    localparam int unsigned PAD_W     = 8 - IDX_W;
    localparam logic [7:0]  DATA_PORT = PORT_BASE + 8'd1;

    logic             hit_index;
    logic             hit_data;
    logic             wr_index_port;
    logic             wr_data_port;
    logic [IDX_W-1:0] index_q;
    logic [7:0]       idx8;
    rtc_field_e       sel_field;
    logic             sel_sta;
    logic             sel_stb;
    logic [6:0]       stat_a_q;
    logic [7:0]       stat_b_q;
    logic             fmt_bin;
    logic             seq_uip;
    logic             seq_commit;
    logic             cal_wr_en;
    rtc_field_e       cal_field;
    logic [7:0]       cal_val;
    rtc_time_t        now;
    logic             nv_wr;
    logic [7:0]       nv_rd_data;
    logic [7:0]       field_bin;
    logic [7:0]       data_rd;

    assign hit_index     = (io_addr == PORT_BASE);
    assign hit_data      = (io_addr == DATA_PORT);
    assign wr_index_port = io_wr && hit_index;
    assign wr_data_port  = io_wr && hit_data;
    assign idx8          = {{PAD_W{1'b0}}, index_q};
    assign fmt_bin       = stat_b_q[FMT_BIN_BIT];

    // Register number decode
    always_comb begin
        sel_field = FLD_NONE;
        sel_sta   = 1'b0;
        sel_stb   = 1'b0;
        case (idx8)
            REG_SEC:    sel_field = FLD_SEC;
            REG_MIN:    sel_field = FLD_MIN;
            REG_HOUR:   sel_field = FLD_HOUR;
            REG_DAY:    sel_field = FLD_DAY;
            REG_MON:    sel_field = FLD_MON;
            REG_YEAR:   sel_field = FLD_YEAR;
            REG_STAT_A: sel_sta   = 1'b1;
            REG_STAT_B: sel_stb   = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (wr_index_port) begin
            index_q <= io_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_a_q <= '0;
            stat_b_q <= '0;
        end else if (wr_data_port) begin
            if (sel_sta) stat_a_q <= io_wdata[6:0];
            if (sel_stb) stat_b_q <= io_wdata;
        end
    end

    assign cal_wr_en = wr_data_port && (sel_field != FLD_NONE);
    assign cal_field = sel_field;
    assign cal_val   = fmt_bin ? io_wdata : bcd_to_bin(io_wdata);
    assign nv_wr     = wr_data_port && (sel_field == FLD_NONE) && !sel_sta && !sel_stb;

    rtc_sequencer #(
        .TICKS (TICKS_PER_SEC),
        .LEAD  (UIP_LEAD)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .uip    (seq_uip),
        .commit (seq_commit)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (seq_commit),
        .wr_en    (cal_wr_en),
        .wr_field (cal_field),
        .wr_val   (cal_val),
        .now      (now)
    );

    rtc_scratch #(
        .DEPTH (NV_BYTES),
        .IDX_W (IDX_W)
    ) u_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (nv_wr),
        .wr_idx  (index_q),
        .wr_data (io_wdata),
        .rd_idx  (index_q),
        .rd_data (nv_rd_data)
    );

    // Read path
    always_comb begin
        case (sel_field)
            FLD_SEC:  field_bin = now.sec;
            FLD_MIN:  field_bin = now.min;
            FLD_HOUR: field_bin = now.hour;
            FLD_DAY:  field_bin = now.day;
            FLD_MON:  field_bin = now.mon;
            FLD_YEAR: field_bin = now.year;
            default:  field_bin = 8'h00;
        endcase
    end

    always_comb begin
        if (sel_sta) begin
            data_rd = {seq_uip, stat_a_q};
        end else if (sel_stb) begin
            data_rd = stat_b_q;
        end else if (sel_field != FLD_NONE) begin
            data_rd = fmt_bin ? field_bin : bin_to_bcd(field_bin);
        end else begin
            data_rd = nv_rd_data;
        end
    end

    always_comb begin
        if (hit_index) begin
            io_rdata = idx8;
        end else if (hit_data) begin
            io_rdata = data_rd;
        end else begin
            io_rdata = 8'h00;
        end
    end

endmodule

// File: rtl/rtc_indexed_chk.sv
module rtc_indexed_chk
    import rtc_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             uip,
    input logic             commit,
    input logic             cal_wr,
    input rtc_field_e       cal_field,
    input logic [7:0]       sec,
    input logic [IDX_W-1:0] index_q,
    input logic             idx_wr
);

    logic sec_wr;
    assign sec_wr = cal_wr && (cal_field == FLD_SEC);

    AST_COMMIT_UNDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> uip); // R5

    AST_FLAG_DROPS_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !uip); // R5

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |=> uip); // R5

    AST_SEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(commit) && !$past(sec_wr)) |-> $stable(sec)); // R4

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(commit) && !$past(sec_wr) && ($past(sec) < 8'd59)) |-> (sec == $past(sec) + 8'd1)); // R4

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(commit) && !$past(sec_wr) && ($past(sec) >= 8'd59)) |-> (sec == 8'd0)); // R6

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(idx_wr) |-> $stable(index_q)); // R1

endmodule

bind rtc_indexed rtc_indexed_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uip       (seq_uip),
    .commit    (seq_commit),
    .cal_wr    (cal_wr_en),
    .cal_field (cal_field),
    .sec       (now.sec),
    .index_q   (index_q),
    .idx_wr    (wr_index_port)
);

// File: tb/rtc_indexed_bench.sv
module rtc_indexed_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 40;
    localparam int LEAD       = 4;
    localparam logic [7:0] IDX = 8'h70;
    localparam logic [7:0] DAT = 8'h71;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = DAT;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference model state
    int m_cnt, m_idx, m_a, m_b;
    int m_sec, m_min, m_hour, m_day, m_mon, m_year;
    int m_nv [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_indexed #(
        .PORT_BASE     (IDX),
        .TICKS_PER_SEC (TICKS),
        .UIP_LEAD      (LEAD),
        .NV_BYTES      (64)
    ) u_rtc_indexed (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata)
    );

    function automatic int mdays(input int mo, input int yr);
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        return 31;
    endfunction

    function automatic int show(input int v);
        if ((m_b & 4) != 0) return v & 255;
        return (((v / 10) << 4) | (v % 10)) & 255;
    endfunction

    function automatic int take(input int w);
        if ((m_b & 4) != 0) return w;
        return ((w >> 4) * 10) + (w & 15);
    endfunction

    function automatic int m_uip();
        return (m_cnt >= TICKS - LEAD) ? 1 : 0;
    endfunction

    function automatic int m_rd(input logic [7:0] a);
        if (a == IDX) return m_idx;
        if (a != DAT) return 0;
        case (m_idx)
            0:  return show(m_sec);
            2:  return show(m_min);
            4:  return show(m_hour);
            7:  return show(m_day);
            8:  return show(m_mon);
            9:  return show(m_year);
            10: return (m_uip() << 7) | m_a;
            11: return m_b;
            default: return m_nv[m_idx];
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a == IDX) return "R1";
        if (a != DAT) return "R2";
        case (m_idx)
            0:       return "R4";
            2, 4:    return "R6";
            7, 8:    return "R7";
            9:       return "R8";
            10:      return "R5";
            11:      return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic model_advance();
        if (m_sec >= 59) begin
            m_sec = 0;
            if (m_min >= 59) begin
                m_min = 0;
                if (m_hour >= 23) begin
                    m_hour = 0;
                    if (m_day >= mdays(m_mon, m_year)) begin
                        m_day = 1;
                        if (m_mon >= 12) begin
                            m_mon = 1;
                            m_year = (m_year >= 99) ? 0 : m_year + 1;
                        end else m_mon++;
                    end else m_day++;
                end else m_hour++;
            end else m_min++;
        end else m_sec++;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_idx = 0; m_a = 0; m_b = 0;
            m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_mon = 1; m_year = 0;
            for (int i = 0; i < 64; i++) m_nv[i] = 0;
        end else begin
            if (m_cnt == TICKS - 1) begin
                model_advance();
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            if (io_wr && io_addr == IDX) begin
                m_idx = int'(io_wdata) & 63;
            end else if (io_wr && io_addr == DAT) begin
                case (m_idx)
                    0:  m_sec  = take(int'(io_wdata));
                    2:  m_min  = take(int'(io_wdata));
                    4:  m_hour = take(int'(io_wdata));
                    7:  m_day  = take(int'(io_wdata));
                    8:  m_mon  = take(int'(io_wdata));
                    9:  m_year = take(int'(io_wdata));
                    10: m_a    = int'(io_wdata) & 127;
                    11: m_b    = int'(io_wdata);
                    default: m_nv[m_idx] = int'(io_wdata);
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) chk(tag_of(io_addr), int'(io_rdata), m_rd(io_addr));
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0; io_addr = DAT;
    endtask

    task automatic set_reg(input logic [7:0] r, input logic [7:0] v);
        wr(IDX, r);
        wr(DAT, v);
    endtask

    task automatic expect_reg(input logic [7:0] r, input int exp, input string tag);
        wr(IDX, r);
        io_addr = DAT;
        @(negedge clk);
        chk(tag, int'(io_rdata), exp);
        @(posedge clk); #1;
    endtask

    task automatic wait_cnt(input int n);
        do begin
            @(posedge clk); #1;
        end while (m_cnt != n);
    endtask

    task automatic set_time(input logic [7:0] yy, mo, dd, hh, mi, ss);
        set_reg(8'h09, yy); set_reg(8'h08, mo); set_reg(8'h07, dd);
        set_reg(8'h04, hh); set_reg(8'h02, mi); set_reg(8'h00, ss);
    endtask

    task automatic roll(input logic [7:0] yy, mo, dd, hh, mi, ss,
                        input int e_yy, e_mo, e_dd, e_hh, e_mi, input string tag);
        wait_cnt(1);
        set_time(yy, mo, dd, hh, mi, ss);
        wait_cnt(0);
        expect_reg(8'h09, e_yy, tag);
        expect_reg(8'h08, e_mo, tag);
        expect_reg(8'h07, e_dd, tag);
        expect_reg(8'h04, e_hh, tag);
        expect_reg(8'h02, e_mi, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        expect_reg(8'h00, 8'h00, "R12");
        expect_reg(8'h07, 8'h01, "R12");
        expect_reg(8'h08, 8'h01, "R12");
        expect_reg(8'h09, 8'h00, "R12");
        expect_reg(8'h0B, 8'h00, "R12");
        expect_reg(8'h0F, 8'h00, "R12");

        // R1 index keeps low six bits
        wr(IDX, 8'hC7);
        io_addr = IDX;
        @(negedge clk); chk("R1", int'(io_rdata), 8'h07);
        @(posedge clk); #1;

        // R3 storage bytes
        set_reg(8'h0F, 8'hA5);
        set_reg(8'h20, 8'h3C);
        expect_reg(8'h0F, 8'hA5, "R3");
        expect_reg(8'h20, 8'h3C, "R3");

        // R2 foreign addresses
        wr(8'h72, 8'h55);
        wr(8'h6F, 8'h11);
        io_addr = 8'h72;
        @(negedge clk); chk("R2", int'(io_rdata), 8'h00);
        @(posedge clk); #1;
        io_addr = IDX;
        @(negedge clk); chk("R2", int'(io_rdata), 8'h20);
        @(posedge clk); #1;
        io_addr = DAT;
        @(negedge clk); chk("R2", int'(io_rdata), 8'h3C);
        @(posedge clk); #1;

        // R11 status A low bits writable, top bit is the flag
        set_reg(8'h0A, 8'hFF);
        @(negedge clk); chk("R11", int'(io_rdata) & 8'h7F, 8'h7F);
        chk("R11", int'(io_rdata) >> 7, m_uip());
        @(posedge clk); #1;

        // R5 flag edges
        wait_cnt(TICKS - LEAD - 1);
        @(negedge clk); chk("R5", int'(io_rdata[7]), 0);
        wait_cnt(TICKS - LEAD);
        @(negedge clk); chk("R5", int'(io_rdata[7]), 1);
        wait_cnt(TICKS - 1);
        @(negedge clk); chk("R5", int'(io_rdata[7]), 1);
        wait_cnt(0);
        @(negedge clk); chk("R5", int'(io_rdata[7]), 0);
        repeat (2 * TICKS) @(posedge clk);
        #1;

        // R4 one step per second
        wait_cnt(1);
        set_reg(8'h00, 8'h10);
        wait_cnt(0);
        expect_reg(8'h00, 8'h11, "R4");
        io_addr = DAT;
        repeat (3 * TICKS) @(posedge clk);
        #1;

        // R6 R7 R8 rollover chains
        roll(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, "R8");
        roll(8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h03, 8'h03, 8'h01, 8'h00, 8'h00, "R7");
        roll(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h04, 8'h02, 8'h29, 8'h00, 8'h00, "R7");
        roll(8'h04, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59, 8'h04, 8'h03, 8'h01, 8'h00, 8'h00, "R7");
        roll(8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59, 8'h21, 8'h05, 8'h01, 8'h00, 8'h00, "R7");
        roll(8'h21, 8'h06, 8'h15, 8'h10, 8'h59, 8'h59, 8'h21, 8'h06, 8'h15, 8'h11, 8'h00, "R6");
        roll(8'h21, 8'h06, 8'h15, 8'h10, 8'h45, 8'h59, 8'h21, 8'h06, 8'h15, 8'h10, 8'h46, "R6");

        // R9 binary and decimal presentation
        wait_cnt(1);
        set_reg(8'h0B, 8'h04);
        set_reg(8'h04, 8'd23);
        set_reg(8'h02, 8'd10);
        set_reg(8'h00, 8'd5);
        expect_reg(8'h04, 23, "R9");
        set_reg(8'h0B, 8'h00);
        expect_reg(8'h04, 8'h23, "R9");
        expect_reg(8'h02, 8'h10, "R9");

        // R10 write in the update cycle
        wait_cnt(1);
        set_reg(8'h00, 8'h30);
        wait_cnt(TICKS - 1);
        wr(DAT, 8'h05);
        expect_reg(8'h00, 8'h05, "R10");
        wait_cnt(1);
        set_reg(8'h02, 8'h20);
        set_reg(8'h00, 8'h59);
        wr(IDX, 8'h02);
        wait_cnt(TICKS - 1);
        wr(DAT, 8'h40);
        expect_reg(8'h02, 8'h40, "R10");
        expect_reg(8'h00, 8'h00, "R10");

        repeat (TICKS) @(posedge clk);
        finish_run();
    end

endmodule